// File: doc/BRIEF.md
# Dual-Channel DAC Serial Latch Controller

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. A host shifts a 16-bit command word in, most significant bit first, on rising edges of a serial clock while an active-low chip select is held low. The top four bits of the word are program bits. The low twelve bits are the new converter code.

The program bits decide which holding registers take the new code. There are three of them: the channel A latch, the channel B latch, and a staging register. The staging register lets both channels change on the same clock. The host first loads the staging register alone. A later channel A write then copies the staging register into channel B in the same cycle.

The word also sets two registered control flags, fast settling and power down. Setting power down never clears a code, so when the converter wakes it drives the codes it held before. All serial inputs are brought into the system clock domain through synchronizer flops before any decoding.

Top module: `dac_serial_latch`

## Requirements
- R1: After an active-low reset, both channel codes are 0, the staging register is 0, fast settling is 0 and power down is 0.
- R2: While chip select is low, a bit is taken MSB first on each rising serial clock edge. The 16th edge applies the word, and the outputs change on the third system clock rising edge after that serial edge.
- R3: A word with bit 15 = 1 loads bits 11..0 into channel A and copies the staging register into channel B. The staging register keeps its value.
- R4: A word with bit 15 = 0 and bit 12 = 0 loads bits 11..0 into both channel B and the staging register. Channel A is unchanged.
- R5: A word with bit 15 = 0 and bit 12 = 1 loads bits 11..0 into the staging register only. Channels A and B keep their values.
- R6: Every applied word sets fast settling to its bit 14 (1 = fast, 0 = slow).
- R7: Every applied word sets power down to its bit 13 (1 = powered down). The channel codes are not cleared by power down.
- R8: If chip select rises before 16 bits have been taken, the frame is discarded. No code or flag changes.
- R9: Serial clock edges after the 16th in the same frame are ignored. There is exactly one transfer per frame.
- R10: The bit count restarts whenever chip select is high. Serial clock edges while chip select is high are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select (asynchronous) |
| sclk | input | 1 | Serial clock (asynchronous, sampled) |
| sdi | input | 1 | Serial data, MSB first |
| code_a | output | 12 | Channel A converter code |
| code_b | output | 12 | Channel B converter code |
| fast_settle | output | 1 | 1 selects fast settling |
| power_down | output | 1 | 1 puts the converter into power down |

## Verification
The serial clock passes through two synchronizer flops and one edge-detect flop. The codes and flags therefore change on the third system clock rising edge after the 16th rising serial edge, and not before. The reference model in the bench counts exactly three rising edges after it raises the 16th serial edge and applies the word only then. The outputs are compared with the model on every falling edge, so a transfer that arrives one cycle early or late fails. Discarded, overlong and idle-clock frames cause no model update, so any output change after them also fails.

// File: rtl/dac_serial_latch.sv
`timescale 1ns/1ps
module dac_serial_latch #(
  parameter int CODE_W = 12,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              fast_settle,
  output logic              power_down
);
  localparam int WORD_W = CODE_W + 4;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [SYNC:0]       sclk_q;
  logic [SYNC-1:0]     sdi_q, cs_q;
  logic [WORD_W-2:0]   shreg;
  logic [CNT_W-1:0]    cnt;
  logic                done;
  logic [CODE_W-1:0]   stage;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      sdi_q  <= '0;
      cs_q   <= '1;
    end else begin
      sclk_q <= {sclk_q[SYNC-1:0], sclk};
      sdi_q  <= {sdi_q[SYNC-2:0], sdi};
      cs_q   <= {cs_q[SYNC-2:0], cs_n};
    end

  wire               cs_act = ~cs_q[SYNC-1];
  wire               take   = cs_act & sclk_q[SYNC-1] & ~sclk_q[SYNC] & ~done;
  wire [WORD_W-1:0]  word   = {shreg, sdi_q[SYNC-1]};
  wire               xfer   = take && (cnt == LAST);
  wire [CODE_W-1:0]  code   = word[CODE_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      done  <= 1'b0;
    end else if (!cs_act) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (take) begin
      shreg <= word[WORD_W-2:0];
      cnt   <= cnt + 1'b1;
      if (cnt == LAST) done <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      code_a      <= '0;
      code_b      <= '0;
      stage       <= '0;
      fast_settle <= 1'b0;
      power_down  <= 1'b0;
    end else if (xfer) begin
      fast_settle <= word[WORD_W-2];
      power_down  <= word[WORD_W-3];
      if (word[WORD_W-1]) begin
        code_a <= code;
        code_b <= stage;
      end else if (!word[CODE_W]) begin
        code_b <= code;
        stage  <= code;
      end else begin
        stage  <= code;
      end
    end

  // R10: count is cleared one cycle after chip select is seen high
  a_r10_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> cnt == '0);
  // R9: once a frame has transferred, nothing moves until the frame ends
  a_r9_single_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> ($stable(code_a) && $stable(code_b) && $stable(stage)));
  // R3: staging register untouched by a channel A write
  a_r3_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && word[WORD_W-1]) |=> $stable(stage));
  // R4: a channel B write leaves B and staging equal
  a_r4_b_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !word[WORD_W-1] && !word[CODE_W]) |=> code_b == stage);
  // R7: power flag follows bit 13 of each applied word
  a_r7_power_flag: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> power_down == $past(word[WORD_W-3]));
  // R2: count never passes the word length
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(WORD_W));
endmodule

// File: tb/test_dac_serial_latch.sv
`timescale 1ns/1ps
module test_dac_serial_latch;
  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0;
  logic [11:0] code_a, code_b;
  logic fast_settle, power_down;
  int checks = 0, errors = 0;
  bit chk_en = 0;
  string cur_req = "R1";
  logic [11:0] ma = 0, mb = 0, md = 0;
  logic mf = 0, mp = 0;

  always #2 clk = ~clk;

  dac_serial_latch i_dac_serial_latch (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .code_a(code_a), .code_b(code_b), .fast_settle(fast_settle), .power_down(power_down));

  task automatic cmp(string req);
    checks++;
    if (code_a !== ma || code_b !== mb || fast_settle !== mf || power_down !== mp) begin
      errors++;
      $display("FAIL %s: got a=%h b=%h f=%b p=%b, expected a=%h b=%h f=%b p=%b",
               req, code_a, code_b, fast_settle, power_down, ma, mb, mf, mp);
    end
  endtask

  always @(negedge clk) if (chk_en) cmp(cur_req);

  task automatic apply(input logic [15:0] w);
    mf = w[14];
    mp = w[13];
    if (w[15]) begin ma = w[11:0]; mb = md; end
    else if (!w[12]) begin mb = w[11:0]; md = w[11:0]; end
    else md = w[11:0];
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, input int extra);
    @(negedge clk) cs_n = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits + extra; i++) begin
      sclk = 0;
      sdi = (i < 16) ? w[15-i] : 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1;
      if (i == 15) begin
        repeat (3) @(posedge clk);
        apply(w);
        @(negedge clk);
      end else repeat (4) @(negedge clk);
    end
    sclk = 0;
    repeat (4) @(negedge clk);
    cs_n = 1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp("R1");
    chk_en = 1;
    cur_req = "R4"; frame(16'h0ABC, 16, 0);
    cur_req = "R3"; frame(16'h8123, 16, 0);
    cur_req = "R5"; frame(16'h1555, 16, 0);
    cur_req = "R3"; frame(16'h8777, 16, 0);
    cur_req = "R6"; frame(16'h4321, 16, 0);
    cur_req = "R6"; frame(16'hC0F0, 16, 0);
    cur_req = "R7"; frame(16'h3999, 16, 0);
    cur_req = "R7"; frame(16'h8444, 16, 0);
    cur_req = "R9"; frame(16'h0F0F, 16, 7);
    cur_req = "R8"; frame(16'h8FFF, 15, 0);
    cur_req = "R8"; frame(16'h0000, 1, 0);
    cur_req = "R10";
    for (int k = 0; k < 6; k++) begin
      @(negedge clk) sclk = 1; repeat (4) @(negedge clk);
      sclk = 0; repeat (4) @(negedge clk);
    end
    frame(16'h8FFF, 11, 0);
    cur_req = "R2"; frame(16'hA5A5, 16, 0);
    chk_en = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule